// File: doc/BRIEF.md
# Periodic Countdown Timer with Sticky Event Flag

This block produces a repeating event every N ticks of a chosen time base, where N is a 12-bit preset that the host programs. Four tick inputs arrive from an external prescaler as single-cycle pulses: a fast 4096 Hz rate, a 64 Hz rate, one per second and one per minute. A 2-bit source field picks one of them. The selectable rates give periods from roughly a quarter of a millisecond up to 4095 minutes.

When the timer is switched on, a down-counter takes the preset value. Each selected tick lowers the counter by one. When a tick arrives with the counter at 1, the block records an event. It sets a sticky flag, puts the preset back into the counter, and keeps running. The host clears the flag by writing a zero to it. The interrupt request is the flag masked by an interrupt-enable bit. The current counter value is also brought out so that the host can observe the countdown.

Control is a small state machine with three states:
- `ST_OFF`: the timer is stopped and the counter holds its value.
- `ST_RUN`: the timer is counting down.
- `ST_EMPTY`: the timer is enabled but was loaded with zero, so it never fires.

Transitions:
- OFF→RUN: the enable bit is seen set and the preset is non-zero. The counter loads the preset.
- OFF→EMPTY: the enable bit is seen set and the preset is zero. The counter loads zero.
- RUN→RUN on expiry: the event fires and the preset is reloaded.
- RUN→EMPTY on expiry: the event fires while the preset has meanwhile been set to zero.
- RUN→OFF and EMPTY→OFF: the enable bit is cleared.

Top module: `cyc_timer`

## Requirements
- R1: After reset, flag_o, irq_o and count_o are 0, and the preset, enable, source select and interrupt-enable bits are all 0.
- R2: The counter loads the preset on the clock edge after the one that writes a 1 into enable bit 0 of register 2. From the following cycle on, selected ticks are counted.
- R3: Bits 2:1 of register 2 choose the tick source: 0 selects tick_i[0] (4096 Hz), 1 selects tick_i[1] (64 Hz), 2 selects tick_i[2] (1 per second) and 3 selects tick_i[3] (1 per minute). Each selected tick lowers a counter above 1 by one, and ticks on the other inputs change nothing.
- R4: A selected tick while the counter is 1 sets the flag and reloads the counter with the preset on the same edge. The event therefore repeats every preset ticks.
- R5: The flag is bit 0 of register 3. Once set, it stays set until a write to register 3 with bit 0 equal to 0. Writing 1 to that bit has no effect. If an event and a clearing write occur in the same cycle, the flag stays set.
- R6: Bit 1 of register 3 is the interrupt enable. irq_o is high only while both the flag and this enable are 1. Clearing the enable drops irq_o and leaves the flag unchanged.
- R7: A preset of zero leaves the counter at 0 and never sets the flag.
- R8: Clearing the enable bit stops the countdown. The counter holds its value and the flag is unchanged, while ticks keep arriving.
- R9: The preset is register 0 (bits 7:0) together with bits 3:0 of register 1 (bits 11:8). Bits 7:4 of register 1 are ignored. A preset written while running takes effect only at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Host register write strobe |
| wr_addr_i | input | 2 | Register index for the write |
| wr_data_i | input | 8 | Write data |
| tick_i | input | 4 | Single-cycle tick pulses, one per time base |
| flag_o | output | 1 | Sticky expiry flag |
| irq_o | output | 1 | Interrupt request (flag masked by enable) |
| count_o | output | 12 | Current down-counter value |

## Verification
The hardest situation to reach from the ports is an expiry that lands in the same cycle as a host write clearing the flag. The bench arranges it by preloading a small preset and stepping the counter down to 1. It then drives the final selected tick and a flag-clearing write to register 3 on the same falling edge, and expects the flag to remain set. Holding the counter while the timer is disabled is reached the same way. The countdown is stopped partway, and ticks are applied to the now-stopped counter.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_EMPTY = 2'd2
    } tmr_state_t;

    localparam int REG_PRESET_LO = 0;
    localparam int REG_PRESET_HI = 1;
    localparam int REG_MODE      = 2;
    localparam int REG_IRQ       = 3;

    localparam int MODE_EN_BIT   = 0;
    localparam int MODE_SEL_LSB  = 1;
    localparam int IRQ_FLAG_BIT  = 0;
    localparam int IRQ_EN_BIT    = 1;

endpackage

// File: rtl/cyc_timer_regs.sv
module cyc_timer_regs
    import cyc_timer_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 12,
    parameter int SEL_W  = 2,
    parameter int ADDR_W = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              event_i,
    output logic [CNT_W-1:0]  preset_o,
    output logic              run_en_o,
    output logic [SEL_W-1:0]  src_sel_o,
    output logic              flag_o,
    output logic              irq_en_o
);
    localparam int HI_W = CNT_W - DATA_W;

    logic [DATA_W-1:0] preset_lo_q;
    logic [HI_W-1:0]   preset_hi_q;
    logic              wr_lo, wr_hi, wr_mode, wr_irq;

    assign wr_lo   = wr_en_i && (wr_addr_i == ADDR_W'(REG_PRESET_LO));
    assign wr_hi   = wr_en_i && (wr_addr_i == ADDR_W'(REG_PRESET_HI));
    assign wr_mode = wr_en_i && (wr_addr_i == ADDR_W'(REG_MODE));
    assign wr_irq  = wr_en_i && (wr_addr_i == ADDR_W'(REG_IRQ));

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            preset_lo_q <= '0;
            preset_hi_q <= '0;
            run_en_o    <= 1'b0;
            src_sel_o   <= '0;
            irq_en_o    <= 1'b0;
        end else begin
            if (wr_lo)   preset_lo_q <= wr_data_i;
            if (wr_hi)   preset_hi_q <= wr_data_i[HI_W-1:0];
            if (wr_mode) begin
                run_en_o  <= wr_data_i[MODE_EN_BIT];
                src_sel_o <= wr_data_i[MODE_SEL_LSB +: SEL_W];
            end
            if (wr_irq)  irq_en_o <= wr_data_i[IRQ_EN_BIT];
        end
    end

    // Sticky flag: an expiry outranks a clearing write in the same cycle.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            flag_o <= 1'b0;
        else if (event_i)
            flag_o <= 1'b1;
        else if (wr_irq && !wr_data_i[IRQ_FLAG_BIT])
            flag_o <= 1'b0;
    end

    assign preset_o = {preset_hi_q, preset_lo_q};

endmodule

// File: rtl/cyc_timer_tick_sel.sv
module cyc_timer_tick_sel #(
    parameter int NUM_SRC = 4,
    parameter int SEL_W   = 2
) (
    input  logic [NUM_SRC-1:0] tick_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               tick_o
);
    logic [NUM_SRC-1:0] hit;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign hit[g] = tick_i[g] && (sel_i == SEL_W'(g));
    end

    assign tick_o = |hit;

endmodule

// File: rtl/cyc_timer_core.sv
module cyc_timer_core
    import cyc_timer_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_en_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] preset_i,
    output logic [CNT_W-1:0] count_o,
    output logic             event_o,
    output tmr_state_t       state_o
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    tmr_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             preset_zero, expire;

    assign preset_zero = (preset_i == '0);
    assign expire      = run_en_i && tick_i && (cnt_q == CNT_ONE);

    // State register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_OFF;
        else         state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (run_en_i) state_d = preset_zero ? ST_EMPTY : ST_RUN;
            ST_RUN: begin
                if (!run_en_i)              state_d = ST_OFF;
                else if (expire && preset_zero) state_d = ST_EMPTY;
            end
            ST_EMPTY: if (!run_en_i) state_d = ST_OFF;
            default:  state_d = ST_OFF;
        endcase
    end

    // Outputs: counter value and expiry event
    always_comb begin
        cnt_d   = cnt_q;
        event_o = 1'b0;
        unique case (state_q)
            ST_OFF:   if (run_en_i) cnt_d = preset_i;
            ST_RUN: begin
                if (expire) begin
                    event_o = 1'b1;
                    cnt_d   = preset_i;
                end else if (run_en_i && tick_i) begin
                    cnt_d = cnt_q - CNT_ONE;
                end
            end
            ST_EMPTY: cnt_d = cnt_q;
            default:  cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
    assign state_o = state_q;

endmodule

// File: rtl/cyc_timer.sv
module cyc_timer
    import cyc_timer_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int CNT_W   = 12,
    parameter int NUM_SRC = 4,
    parameter int ADDR_W  = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic [NUM_SRC-1:0] tick_i,
    output logic               flag_o,
    output logic               irq_o,
    output logic [CNT_W-1:0]   count_o
);
    localparam int SEL_W = $clog2(NUM_SRC);

    logic [CNT_W-1:0] preset_w;
    logic             run_en_w;
    logic [SEL_W-1:0] sel_w;
    logic             irq_en_w;
    logic             tick_w;
    logic             event_w;
    tmr_state_t       st_w;

    cyc_timer_regs #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .SEL_W  (SEL_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .event_i   (event_w),
        .preset_o  (preset_w),
        .run_en_o  (run_en_w),
        .src_sel_o (sel_w),
        .flag_o    (flag_o),
        .irq_en_o  (irq_en_w)
    );

    cyc_timer_tick_sel #(
        .NUM_SRC (NUM_SRC),
        .SEL_W   (SEL_W)
    ) u_sel (
        .tick_i (tick_i),
        .sel_i  (sel_w),
        .tick_o (tick_w)
    );

    cyc_timer_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_en_i (run_en_w),
        .tick_i   (tick_w),
        .preset_i (preset_w),
        .count_o  (count_o),
        .event_o  (event_w),
        .state_o  (st_w)
    );

    assign irq_o = flag_o && irq_en_w;

endmodule

// File: rtl/cyc_timer_chk.sv
module cyc_timer_chk
    import cyc_timer_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 12,
    parameter int ADDR_W = 2
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic              tick_i,
    input tmr_state_t        st_i,
    input logic              run_en_i,
    input logic              irq_en_i,
    input logic [CNT_W-1:0]  preset_i,
    input logic [CNT_W-1:0]  count_i,
    input logic              flag_i,
    input logic              irq_i
);
    logic clr_wr;
    assign clr_wr = wr_en_i && (wr_addr_i == ADDR_W'(REG_IRQ)) && !wr_data_i[IRQ_FLAG_BIT];

    p_dec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_i == ST_RUN && run_en_i && tick_i && count_i > CNT_W'(1))
        |=> (count_i == $past(count_i) - CNT_W'(1)));

    p_reload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_i == ST_RUN && run_en_i && tick_i && count_i == CNT_W'(1))
        |=> (flag_i && count_i == $past(preset_i)));

    p_flag_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_i && !clr_wr) |=> flag_i);

    p_irq_masked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_en_i |-> !irq_i);

    p_irq_needs_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_i |-> flag_i);

    p_zero_silent_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count_i == '0) |=> !$rose(flag_i));

    p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_en_i |=> $stable(count_i));

endmodule

bind cyc_timer cyc_timer_chk #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .tick_i    (tick_w),
    .st_i      (st_w),
    .run_en_i  (run_en_w),
    .irq_en_i  (irq_en_w),
    .preset_i  (preset_w),
    .count_i   (count_o),
    .flag_i    (flag_o),
    .irq_i     (irq_o)
);

// File: tb/test_cyc_timer.sv
module test_cyc_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [3:0]  tick = '0;
    logic        flag, irq;
    logic [11:0] count;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cyc_timer i_cyc_timer (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .tick_i    (tick),
        .flag_o    (flag),
        .irq_o     (irq),
        .count_o   (count)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input int idx);
        @(negedge clk);
        tick[idx] = 1'b1;
        @(negedge clk);
        tick = '0;
    endtask

    // stop, program preset, clear flag and irq enable, start on source sel
    task automatic setup(input int preset, input int sel);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'(preset));
        wr(2'd1, 8'(preset >> 8));
        wr(2'd3, 8'h00);
        wr(2'd2, 8'(1 | (sel << 1)));
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 flag", int'(flag), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 count", int'(count), 0);
    endtask

    task automatic t_load;
        wr(2'd0, 8'hA5);
        wr(2'd1, 8'hF2);            // upper nibble ignored (R9)
        wr(2'd2, 8'h01);
        chk("R2 no load before edge", int'(count), 0);
        @(negedge clk);
        chk("R2 R9 loaded preset", int'(count), 'h2A5);
    endtask

    task automatic t_select;
        pulse(1); pulse(2); pulse(3);
        chk("R3 unselected ticks ignored", int'(count), 'h2A5);
        pulse(0);
        chk("R3 selected tick decrements", int'(count), 'h2A4);
    endtask

    task automatic t_period;
        setup(3, 2);
        chk("R2 count after start", int'(count), 3);
        pulse(2); pulse(2);
        chk("R4 no event before expiry", int'(flag), 0);
        chk("R3 count at 1", int'(count), 1);
        pulse(2);
        chk("R4 flag on expiry", int'(flag), 1);
        chk("R4 reload", int'(count), 3);
        chk("R6 irq masked", int'(irq), 0);
        pulse(2); pulse(2); pulse(2);
        chk("R4 second period reload", int'(count), 3);
    endtask

    task automatic t_flag;
        wr(2'd3, 8'h03);
        chk("R5 write 1 keeps flag", int'(flag), 1);
        chk("R6 irq raised", int'(irq), 1);
        wr(2'd3, 8'h01);
        chk("R6 irq cancelled", int'(irq), 0);
        chk("R6 flag kept", int'(flag), 1);
        wr(2'd3, 8'h02);
        chk("R5 flag cleared", int'(flag), 0);
        chk("R6 irq low after clear", int'(irq), 0);
    endtask

    task automatic t_race;
        setup(2, 0);
        wr(2'd3, 8'h02);
        pulse(0);
        chk("R3 count 1 before race", int'(count), 1);
        @(negedge clk);
        tick[0] = 1'b1;
        wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h02;
        @(negedge clk);
        tick = '0; wr_en = 1'b0;
        chk("R5 event wins over clear", int'(flag), 1);
        chk("R6 irq on", int'(irq), 1);
        chk("R4 reload in race", int'(count), 2);
    endtask

    task automatic t_zero;
        setup(0, 0);
        for (int i = 0; i < 5; i++) pulse(0);
        chk("R7 zero count", int'(count), 0);
        chk("R7 no flag", int'(flag), 0);
    endtask

    task automatic t_hold;
        setup(3, 3);
        pulse(3); pulse(3); pulse(3);
        chk("R4 minute source expiry", int'(flag), 1);
        pulse(3);
        chk("R3 minute decrement", int'(count), 2);
        wr(2'd2, 8'h06);
        pulse(3); pulse(3); pulse(0);
        chk("R8 count held", int'(count), 2);
        chk("R8 flag unchanged", int'(flag), 1);
    endtask

    task automatic t_preset_change;
        setup(2, 1);
        wr(2'd0, 8'h04);
        chk("R9 running count unaffected", int'(count), 2);
        pulse(1);
        chk("R9 decrement old value", int'(count), 1);
        pulse(1);
        chk("R9 new preset at reload", int'(count), 4);
        chk("R4 flag 64Hz source", int'(flag), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_select();
        t_period();
        t_flag();
        t_race();
        t_zero();
        t_hold();
        t_preset_change();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule